// File: doc/BRIEF.md
# Round-Robin Shared Pin Arbiter

This block lets several external-bus controllers take turns on one set of chip pins. Each controller owns a request/grant pair. The arbiter hands ownership out in round-robin order. While a controller owns the bus, its shared address, its data-out value and its data output enable reach the pad-side outputs through one register stage. The value on the shared data input pins is returned to every controller at once. Signals that a controller does not share pass straight from the controller side to the pad side with no logic in the path.

A request has two meanings, depending on the grant. While a controller is not granted, a high request asks for the bus now. While it is granted, a high request asks to keep the bus for the following cycle. A controller ends an access by dropping its request in its last cycle. Its grant stays high through that cycle and falls at the next edge.

Controllers may use fewer shared bits than the pad bus has. Their bits sit at bit 0 and every bit above their width reads as zero. For cascading, the block presents its own request/grant pair to an arbiter further up. Pad drive is allowed only while that upstream grant is high.

Top module: `pinshare_arbiter`

## Requirements
- R1: A controller that raises its request while no grant is active, and that wins arbitration, sees its grant high in the next clock cycle. The grant is one bit per controller, with bit i belonging to controller i.
- R2: A granted controller keeps its grant for as long as it holds its request high.
- R3: When a granted controller drops its request, its grant stays high for that cycle and falls at the next clock edge.
- R4: Among requesting controllers, the search for the next owner starts at the index after the current or most recent owner and wraps from N-1 to 0. The reset value of the most recent owner is N-1. If another controller requests during the owner's final cycle, it is granted in the very next cycle, with no idle cycle between the two.
- R5: A controller that requests again in the cycle after its final cycle, with no competing requester, is granted again one cycle later.
- R6: No grant is issued while no controller requests, and at most one grant bit is high at any time.
- R7: The pad-side address, data-out and data-enable outputs show, one cycle later, the values the owning controller presents in a cycle where it holds the grant and the upstream grant is high.
- R8: A controller narrower than the pad bus has its bits aligned at bit 0, and every pad bit above its width is 0 while it owns the bus. Data widths default to 16, 8 and 12 bits and address widths to 10, 6 and 10 bits for controllers 0, 1 and 2.
- R9: The pad data input is returned to every controller at the same time, masked to that controller's data width.
- R10: In the cycle after one with no grant, or with the upstream grant low, the pad address, data-out and data-enable outputs are all 0.
- R11: While reset is low, all grants are low and the pad address, data-out and data-enable outputs are 0. This holds as soon as reset goes low, even in the middle of an access.
- R12: The upstream request equals the owner's request while a grant is active, and the OR of all requests while no grant is active.
- R13: The non-shared controller outputs and the pad inputs pass through to the other side unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mReq | input | N | Request, one bit per controller |
| mGnt | output | N | Grant, one bit per controller |
| mAddr | input | N*ADDR_W | Shared address from each controller |
| mDataOut | input | N*DATA_W | Shared data-out from each controller |
| mDataOe | input | N | Data output enable from each controller |
| mDataIn | output | N*DATA_W | Pad data input returned to each controller |
| mPrivOut | input | N*PRIV_W | Non-shared outputs from the controllers |
| mPrivIn | output | N*PRIV_W | Non-shared inputs to the controllers |
| upReq | output | 1 | Request to an upstream arbiter |
| upGnt | input | 1 | Grant from an upstream arbiter (tie high at the root) |
| padAddr | output | ADDR_W | Registered shared address toward the pads |
| padDataOut | output | DATA_W | Registered shared data toward the pads |
| padDataOe | output | 1 | Registered data output enable toward the pads |
| padDataIn | input | DATA_W | Shared data input from the pads |
| padPrivOut | output | N*PRIV_W | Non-shared outputs toward the pads |
| padPrivIn | input | N*PRIV_W | Non-shared inputs from the pads |

## Verification
The bench builds the block with three controllers. Data widths are 16, 8 and 12 bits and address widths are 10, 6 and 10 bits, with two private bits per controller. Because the count is not a power of two, the round-robin search has to wrap from index 2 back to 0 by subtraction rather than by bit truncation. The narrow controllers drive ones in their upper bits, so any missing zero-extension shows up on the pad outputs and on the returned input. The bench also covers back-to-back handover in the owner's final cycle, the one-cycle gap when the same controller asks again, the upstream grant held low, and a reset in the middle of an access.

// File: rtl/pinshare_pkg.sv
package pinshare_pkg;

  // Owner index field is sized for the largest supported controller count.
  localparam int OWNER_BITS  = 4;
  localparam int MAX_MASTERS = 1 << OWNER_BITS;

  // Strobes from the arbitration control to the pin datapath.
  typedef struct packed {
    logic                  drive;  // an owner exists and upstream allows drive
    logic [OWNER_BITS-1:0] owner;  // index of the owning controller
  } busCtl_t;

endpackage

// File: rtl/pinshare_rr_pick.sv
module pinshare_rr_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] startIdx,
  output logic             found,
  output logic [IDX_W-1:0] pick
);

  int cand;

  // Scan N positions beginning at startIdx, wrapping by subtraction so that
  // counts that are not a power of two are handled.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = 0;
    for (int k = 0; k < N; k++) begin
      cand = int'(startIdx) + k;
      if (cand >= N) cand = cand - N;
      if (!found && req[cand]) begin
        found = 1'b1;
        pick  = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/pinshare_ctrl.sv
module pinshare_ctrl
  import pinshare_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] mReq,
  input  logic         upGnt,
  output logic [N-1:0] mGnt,
  output logic         upReq,
  output busCtl_t      ctl
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic [N-1:0]     gntQ, gntD;
  logic [IDX_W-1:0] ownerQ, ownerD;
  logic [IDX_W-1:0] lastQ, lastD;
  logic [IDX_W-1:0] startIdx, pick;
  logic             busyQ, holdNext, found;

  function automatic logic [IDX_W-1:0] wrapInc(input logic [IDX_W-1:0] x);
    return (x == LAST_IDX) ? '0 : x + IDX_W'(1);
  endfunction

  assign busyQ    = |gntQ;
  // A granted request means "also the next cycle".
  assign holdNext = busyQ && mReq[ownerQ];
  assign startIdx = busyQ ? wrapInc(ownerQ) : wrapInc(lastQ);

  pinshare_rr_pick #(
    .N    (N),
    .IDX_W(IDX_W)
  ) u_pick (
    .req     (mReq),
    .startIdx(startIdx),
    .found   (found),
    .pick    (pick)
  );

  always_comb begin
    gntD   = gntQ;
    ownerD = ownerQ;
    lastD  = lastQ;
    if (!holdNext) begin
      if (busyQ) lastD = ownerQ;
      gntD = '0;
      if (found) begin
        gntD   = N'(1) << pick;
        ownerD = pick;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gntQ   <= '0;
      ownerQ <= '0;
      lastQ  <= LAST_IDX;
    end else begin
      gntQ   <= gntD;
      ownerQ <= ownerD;
      lastQ  <= lastD;
    end
  end

  assign mGnt      = gntQ;
  assign upReq     = busyQ ? mReq[ownerQ] : |mReq;
  assign ctl.drive = busyQ && upGnt;
  assign ctl.owner = OWNER_BITS'(ownerQ);

endmodule

// File: rtl/pinshare_datapath.sv
module pinshare_datapath
  import pinshare_pkg::*;
#(
  parameter int            N           = 3,
  parameter int            DATA_W      = 16,
  parameter int            ADDR_W      = 10,
  parameter logic [N*8-1:0] DATA_WIDTHS = {8'd12, 8'd8, 8'd16},
  parameter logic [N*8-1:0] ADDR_WIDTHS = {8'd10, 8'd6, 8'd10}
) (
  input  logic                clk,
  input  logic                rstN,
  input  busCtl_t             ctl,
  input  logic [N*ADDR_W-1:0] mAddr,
  input  logic [N*DATA_W-1:0] mDataOut,
  input  logic [N-1:0]        mDataOe,
  output logic [N*DATA_W-1:0] mDataIn,
  input  logic [DATA_W-1:0]   padDataIn,
  output logic [ADDR_W-1:0]   padAddr,
  output logic [DATA_W-1:0]   padDataOut,
  output logic                padDataOe
);

  logic [DATA_W-1:0] dMask [N];
  logic [ADDR_W-1:0] aMask [N];
  logic [DATA_W-1:0] selData;
  logic [ADDR_W-1:0] selAddr;
  logic              selOe;

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam int DW_RAW = int'(DATA_WIDTHS[i*8 +: 8]);
    localparam int AW_RAW = int'(ADDR_WIDTHS[i*8 +: 8]);
    localparam int DW     = (DW_RAW > DATA_W) ? DATA_W : DW_RAW;
    localparam int AW     = (AW_RAW > ADDR_W) ? ADDR_W : AW_RAW;
    assign dMask[i] = {DATA_W{1'b1}} >> (DATA_W - DW);
    assign aMask[i] = {ADDR_W{1'b1}} >> (ADDR_W - AW);
    // Input fan-back: every controller sees the pads, cut to its width.
    assign mDataIn[i*DATA_W +: DATA_W] = padDataIn & dMask[i];
  end

  always_comb begin
    selData = '0;
    selAddr = '0;
    selOe   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ctl.drive && (ctl.owner == OWNER_BITS'(i))) begin
        selData = mDataOut[i*DATA_W +: DATA_W] & dMask[i];
        selAddr = mAddr[i*ADDR_W +: ADDR_W] & aMask[i];
        selOe   = mDataOe[i];
      end
    end
  end

  // Registered pad side: enables come out of reset switched off.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      padDataOut <= '0;
      padAddr    <= '0;
      padDataOe  <= 1'b0;
    end else begin
      padDataOut <= selData;
      padAddr    <= selAddr;
      padDataOe  <= selOe;
    end
  end

endmodule

// File: rtl/pinshare_arbiter.sv
module pinshare_arbiter
  import pinshare_pkg::*;
#(
  parameter int            N           = 3,
  parameter int            DATA_W      = 16,
  parameter int            ADDR_W      = 10,
  parameter int            PRIV_W      = 2,
  parameter logic [N*8-1:0] DATA_WIDTHS = {8'd12, 8'd8, 8'd16},
  parameter logic [N*8-1:0] ADDR_WIDTHS = {8'd10, 8'd6, 8'd10}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N-1:0]        mReq,
  output logic [N-1:0]        mGnt,
  input  logic [N*ADDR_W-1:0] mAddr,
  input  logic [N*DATA_W-1:0] mDataOut,
  input  logic [N-1:0]        mDataOe,
  output logic [N*DATA_W-1:0] mDataIn,
  input  logic [N*PRIV_W-1:0] mPrivOut,
  output logic [N*PRIV_W-1:0] mPrivIn,
  output logic                upReq,
  input  logic                upGnt,
  output logic [ADDR_W-1:0]   padAddr,
  output logic [DATA_W-1:0]   padDataOut,
  output logic                padDataOe,
  input  logic [DATA_W-1:0]   padDataIn,
  output logic [N*PRIV_W-1:0] padPrivOut,
  input  logic [N*PRIV_W-1:0] padPrivIn
);

  busCtl_t ctl;

  pinshare_ctrl #(
    .N(N)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .mReq (mReq),
    .upGnt(upGnt),
    .mGnt (mGnt),
    .upReq(upReq),
    .ctl  (ctl)
  );

  pinshare_datapath #(
    .N          (N),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .DATA_WIDTHS(DATA_WIDTHS),
    .ADDR_WIDTHS(ADDR_WIDTHS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .mAddr     (mAddr),
    .mDataOut  (mDataOut),
    .mDataOe   (mDataOe),
    .mDataIn   (mDataIn),
    .padDataIn (padDataIn),
    .padAddr   (padAddr),
    .padDataOut(padDataOut),
    .padDataOe (padDataOe)
  );

  // Non-shared signals bypass arbitration.
  assign padPrivOut = mPrivOut;
  assign mPrivIn    = padPrivIn;

endmodule

// File: rtl/pinshare_arbiter_chk.sv
module pinshare_arbiter_chk #(
  parameter int N      = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [N-1:0]      mReq,
  input logic [N-1:0]      mGnt,
  input logic              upGnt,
  input logic [ADDR_W-1:0] padAddr,
  input logic [DATA_W-1:0] padDataOut,
  input logic              padDataOe
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mGnt)); // R6

  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ((mGnt & ~$past(mGnt)) & ~$past(mReq)) == '0); // R1

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((mGnt & mReq) != '0) |=> ((mGnt & $past(mGnt & mReq)) == $past(mGnt & mReq))); // R2

  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ((mGnt & ~mReq) != '0) |=> ((mGnt & $past(mGnt & ~mReq)) == '0)); // R3

  AST_NO_DEFAULT_GNT: assert property (@(posedge clk) disable iff (!rstN)
    (mReq == '0 && mGnt == '0) |=> (mGnt == '0)); // R6

  AST_IDLE_PADS: assert property (@(posedge clk) disable iff (!rstN)
    (mGnt == '0 || !upGnt) |=> (padDataOe == 1'b0 && padDataOut == '0 && padAddr == '0)); // R10

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_PADS: assert (padDataOe == 1'b0 && padDataOut == '0 && padAddr == '0 && mGnt == '0); // R11
    end
  end

endmodule

bind pinshare_arbiter pinshare_arbiter_chk #(
  .N     (N),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .mReq      (mReq),
  .mGnt      (mGnt),
  .upGnt     (upGnt),
  .padAddr   (padAddr),
  .padDataOut(padDataOut),
  .padDataOe (padDataOe)
);

// File: tb/pinshare_arbiter_bench.sv
module pinshare_arbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N      = 3;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int PRIV_W = 2;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              oe;
    logic [ADDR_W-1:0] addr;
    string             tag;
  } padItem_t;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [N-1:0]        mReq = '0;
  logic [N-1:0]        mGnt;
  logic [N*ADDR_W-1:0] mAddr = '0;
  logic [N*DATA_W-1:0] mDataOut = '0;
  logic [N-1:0]        mDataOe = '0;
  logic [N*DATA_W-1:0] mDataIn;
  logic [N*PRIV_W-1:0] mPrivOut = '0;
  logic [N*PRIV_W-1:0] mPrivIn;
  logic                upReq;
  logic                upGnt = 1'b1;
  logic [ADDR_W-1:0]   padAddr;
  logic [DATA_W-1:0]   padDataOut;
  logic                padDataOe;
  logic [DATA_W-1:0]   padDataIn = '0;
  logic [N*PRIV_W-1:0] padPrivOut;
  logic [N*PRIV_W-1:0] padPrivIn = '0;

  padItem_t expQ[$];
  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  done   = 1'b0;
  int  dWid[N] = '{16, 8, 12};
  int  aWid[N] = '{10, 6, 10};

  always #(CLK_PERIOD/2) clk = ~clk;

  pinshare_arbiter u_pinshare_arbiter (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mGnt(mGnt), .mAddr(mAddr),
    .mDataOut(mDataOut), .mDataOe(mDataOe), .mDataIn(mDataIn),
    .mPrivOut(mPrivOut), .mPrivIn(mPrivIn), .upReq(upReq), .upGnt(upGnt),
    .padAddr(padAddr), .padDataOut(padDataOut), .padDataOe(padDataOe),
    .padDataIn(padDataIn), .padPrivOut(padPrivOut), .padPrivIn(padPrivIn)
  );

  function automatic logic [DATA_W-1:0] patD(input int i);
    return 16'hF000 | {4'h0, 4'(i), 8'(cyc)};
  endfunction

  function automatic logic [ADDR_W-1:0] patA(input int i);
    return {4'hF, 6'(cyc + i)};
  endfunction

  function automatic logic [DATA_W-1:0] mskD(input int w);
    return DATA_W'((32'h1 << w) - 1);
  endfunction

  function automatic logic [ADDR_W-1:0] mskA(input int w);
    return ADDR_W'((32'h1 << w) - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares pad outputs with the item queued one cycle earlier.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      padItem_t it;
      it = expQ.pop_front();
      check(padDataOut == it.data, it.tag, "padDataOut", 32'(padDataOut), 32'(it.data));
      check(padDataOe == it.oe, it.tag, "padDataOe", 32'(padDataOe), 32'(it.oe));
      check(padAddr == it.addr, it.tag, "padAddr", 32'(padAddr), 32'(it.addr));
    end
  end

  // Driver: one cycle of stimulus; expOwner is the grant visible now (-1 none).
  task automatic tick(input logic [N-1:0] req, input int expOwner,
                      input logic upg, input string tag);
    padItem_t it;
    logic [N-1:0] expG;
    @(negedge clk);
    #1;
    expG = (expOwner < 0) ? '0 : N'(1) << expOwner;
    check(mGnt == expG, tag, "mGnt", 32'(mGnt), 32'(expG));
    cyc++;
    mReq  = req;
    upGnt = upg;
    for (int i = 0; i < N; i++) begin
      mDataOut[i*DATA_W +: DATA_W] = patD(i);
      mAddr[i*ADDR_W +: ADDR_W]    = patA(i);
      mDataOe[i]                   = 1'b1;
    end
    #1;
    // R12: upstream request
    check(upReq == ((expOwner < 0) ? |req : req[expOwner]), "R12", "upReq",
          32'(upReq), 32'((expOwner < 0) ? |req : req[expOwner]));
    if (expOwner >= 0 && upg) begin
      it.data = patD(expOwner) & mskD(dWid[expOwner]);
      it.addr = patA(expOwner) & mskA(aWid[expOwner]);
      it.oe   = 1'b1;
      it.tag  = "R7/R8";
    end else begin
      it.data = '0;
      it.addr = '0;
      it.oe   = 1'b0;
      it.tag  = "R10";
    end
    expQ.push_back(it);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(mGnt == '0, "R11", "mGnt in reset", 32'(mGnt), 0);
    check(padDataOe == 1'b0 && padDataOut == '0 && padAddr == '0, "R11",
          "pads in reset", 32'(padDataOut), 0);
    #1 rstN = 1'b1;

    tick(3'b000, -1, 1'b1, "R6");
    tick(3'b001, -1, 1'b1, "R6");
    tick(3'b001,  0, 1'b1, "R1");
    tick(3'b000,  0, 1'b1, "R2");
    tick(3'b000, -1, 1'b1, "R3");
    tick(3'b001, -1, 1'b1, "R3");
    tick(3'b000,  0, 1'b1, "R1");
    tick(3'b111, -1, 1'b1, "R3");
    tick(3'b101,  1, 1'b1, "R4");
    tick(3'b001,  2, 1'b1, "R4");
    tick(3'b001,  0, 1'b1, "R4");
    tick(3'b000,  0, 1'b1, "R2");
    tick(3'b010, -1, 1'b1, "R3");
    tick(3'b000,  1, 1'b1, "R1");
    tick(3'b010, -1, 1'b1, "R5");
    tick(3'b000,  1, 1'b1, "R5");
    tick(3'b100, -1, 1'b1, "R6");
    tick(3'b000,  2, 1'b0, "R10");
    tick(3'b000, -1, 1'b1, "R10");
    tick(3'b111, -1, 1'b1, "R6");
    tick(3'b110,  0, 1'b1, "R4");
    tick(3'b100,  1, 1'b1, "R4");
    tick(3'b000,  2, 1'b1, "R4");
    tick(3'b000, -1, 1'b1, "R3");

    // R9: input fan-back, masked per controller width
    padDataIn = 16'hBEEF;
    #1;
    check(mDataIn[0 +: 16] == 16'hBEEF, "R9", "mDataIn[0]", 32'(mDataIn[0 +: 16]), 32'hBEEF);
    check(mDataIn[16 +: 16] == 16'h00EF, "R9", "mDataIn[1]", 32'(mDataIn[16 +: 16]), 32'h00EF);
    check(mDataIn[32 +: 16] == 16'h0EEF, "R9", "mDataIn[2]", 32'(mDataIn[32 +: 16]), 32'h0EEF);

    // R13: private passthrough
    mPrivOut  = 6'b101101;
    padPrivIn = 6'b010011;
    #1;
    check(padPrivOut == 6'b101101, "R13", "padPrivOut", 32'(padPrivOut), 32'b101101);
    check(mPrivIn == 6'b010011, "R13", "mPrivIn", 32'(mPrivIn), 32'b010011);

    // R11: reset in the middle of an access
    tick(3'b001, -1, 1'b1, "R11");
    tick(3'b001,  0, 1'b1, "R11");
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    check(mGnt == '0, "R11", "mGnt after mid reset", 32'(mGnt), 0);
    check(padDataOe == 1'b0 && padDataOut == '0 && padAddr == '0, "R11",
          "pads after mid reset", 32'(padDataOut), 0);
    expQ.delete();
    mReq = '0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule